// File: doc/BRIEF.md
# Host command frame parser

This block sits behind a host serial receiver and turns its byte stream into command frames. It hunts for a fixed two-byte device identifier and then collects a flags byte, a payload length, two command identifier bytes, the payload itself and, when the flags ask for one, a two-byte XOR checksum. Payload bytes go into a local buffer as they arrive. Downstream logic reads them through an address port once the command strobe has fired.

The block also holds the controller's operating mode. Mode-change commands move it between configure-link, configure-peripherals, diagnostic, normal and stop. The mode then decides which peripheral commands are passed on. A corrupted or unexpected frame forces the stop mode. A host that sets the acknowledge flag gets a one-byte acknowledge for every frame that checks out. A frame that stalls between bytes is dropped, and the parser goes back to hunting.

Top module: `cfp_frame_parser`

## Requirements
- R1: The parser discards bytes until it sees 0x93 followed directly by 0x01. If 0x93 is followed by another 0x93, the second one is taken as a possible first identifier byte, so a run 0x93 0x93 0x01 starts a frame. Any other byte after 0x93 restarts the hunt.
- R2: After the identifier, the bytes are taken in this order: flags, length, CID0, CID1, then `length` payload bytes. An accepted command raises `cmd_valid` for exactly one cycle, in the cycle after the final frame byte is taken. In that cycle `cmd_flags`, `cmd_len`, `cmd_cid0` and `cmd_cid1` carry the received values. Payload byte k can be read on `pld_data` with `pld_addr`=k until the next frame arrives.
- R3: A length of 0 is legal. The frame then ends at CID1, or at its checksum bytes when the checksum flag is set. A length of 255 is also legal.
- R4: When the checksum flag is set, two checksum bytes follow the payload, high byte first. They must equal the XOR of all bytes from the first identifier byte to the last payload byte, taken as big-endian 16-bit words, with an odd final byte padded by a 0x00 low byte. On a mismatch no command is issued and the mode becomes stop (4).
- R5: Flags bit 5 is the checksum flag. When it is clear, the frame carries no checksum bytes and ends after the last payload byte.
- R6: Flags bit 7 is the acknowledge flag. When it is set on a frame that passes R4, `ack_valid` pulses for one cycle with `ack_byte` = ACK_CODE (0xA5 by default), in the same cycle as the command strobe would be. There is no acknowledge when the flag is clear or the checksum fails. A frame later refused by the mode rule is still acknowledged.
- R7: After reset, `mode` is configure-link (0) and `cmd_valid` and `ack_valid` are low.
- R8: A frame with CID0=0x10 is a mode change. CID1 values 0, 1, 2, 3 and 4 set `mode` to configure-link (0), configure-peripherals (1), diagnostic (2), normal (3) and stop (4) respectively. A larger CID1 sets stop. A mode change never raises `cmd_valid`.
- R9: An init command (CID0 0x01 or 0x02 with CID1 0x00) is accepted only in configure-peripherals. Every other command is accepted only in normal. A refused command gives no `cmd_valid` and sets the mode to stop.
- R10: If, while a frame is partly received, GAP_LIMIT (1024) consecutive cycles pass with no input byte, the partial frame is dropped and the parser hunts again, without changing the mode. Shorter gaps do not disturb the frame.
- R11: Flags bits other than 7 and 5 (parity and resend requests included) have no effect on parsing. They are reported unchanged in `cmd_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An input byte is present this cycle |
| in_byte | input | 8 | Input byte from the host link |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_cid0 | output | 8 | Command group identifier |
| cmd_cid1 | output | 8 | Command code within the group |
| cmd_len | output | 8 | Payload byte count |
| cmd_flags | output | 8 | Received flags byte |
| pld_addr | input | 8 | Payload read address |
| pld_data | output | 8 | Payload byte at `pld_addr` |
| ack_valid | output | 1 | One-cycle acknowledge strobe |
| ack_byte | output | 8 | Acknowledge code while `ack_valid` is high, else 0 |
| mode | output | 3 | Operating mode: 0 configure-link, 1 configure-peripherals, 2 diagnostic, 3 normal, 4 stop |

## Verification
The hardest case to reach is the inter-byte timeout. It only fires after more than a thousand idle cycles in the middle of a frame, and its result is indistinguishable from normal hunting unless the next bytes would parse differently. The stimulus stops a frame after its CID0 byte and waits a gap just under the limit and one just over it. In the first case the frame resumes and completes. In the second case a fresh frame follows, and it is accepted only if the stale one was dropped. The identifier resynchronisation on a doubled 0x93 is handled the same way, with junk placed in front of a complete frame.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    localparam logic [7:0] ID_HI      = 8'h93;
    localparam logic [7:0] ID_LO      = 8'h01;
    localparam logic [7:0] CID0_MODE  = 8'h10;
    localparam logic [7:0] CID0_SPI   = 8'h01;
    localparam logic [7:0] CID0_PWM   = 8'h02;
    localparam logic [7:0] CID1_INIT  = 8'h00;
    localparam int         FLAG_ACK   = 7;
    localparam int         FLAG_CSUM  = 5;
    localparam int         LEN_W      = 8;
    localparam int         PLD_DEPTH  = 1 << LEN_W;

    typedef enum logic [3:0] {
        P_ID0, P_ID1, P_FLAGS, P_LEN, P_CID0, P_CID1, P_DATA, P_CK0, P_CK1
    } pstate_e;

    typedef enum logic [2:0] {
        M_CONF_COM    = 3'd0,
        M_CONF_PERIPH = 3'd1,
        M_DIAG        = 3'd2,
        M_NORMAL      = 3'd3,
        M_STOP        = 3'd4
    } mode_e;

    typedef struct packed {
        logic [7:0]       flags;
        logic [LEN_W-1:0] len;
        logic [7:0]       cid0;
        logic [7:0]       cid1;
    } hdr_t;

endpackage

// File: rtl/cfp_gap_timer.sv
module cfp_gap_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic byte_seen,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = armed && !byte_seen && (cnt_q == CW'(LIMIT - 1));
        if (!armed || byte_seen || expire) cnt_d = '0;
        else                               cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cfp_byte_parser.sv
module cfp_byte_parser
    import cfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             gap_expire,
    output logic             hunting,
    output logic             wr_en,
    output logic [LEN_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             done,
    output logic             done_ok,
    output hdr_t             done_hdr
);
    typedef struct packed {
        pstate_e          st;
        hdr_t             hdr;
        logic [LEN_W-1:0] cnt;
        logic [15:0]      sum;
        logic             lo_half;
        logic [7:0]       ck_hi;
    } pst_t;

    pst_t q, d;
    logic body_end;
    logic [15:0] sum_acc;

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        wr_addr  = q.cnt;
        wr_data  = in_byte;
        done     = 1'b0;
        done_ok  = 1'b0;
        body_end = 1'b0;
        sum_acc  = q.sum ^ (q.lo_half ? {8'h00, in_byte} : {in_byte, 8'h00});

        if (gap_expire) begin
            d.st = P_ID0;
        end else if (in_valid) begin
            case (q.st)
                P_ID0: begin
                    if (in_byte == ID_HI) begin
                        d.st      = P_ID1;
                        d.sum     = {in_byte, 8'h00};
                        d.lo_half = 1'b1;
                    end
                end
                P_ID1: begin
                    if (in_byte == ID_LO) begin
                        d.st      = P_FLAGS;
                        d.sum     = sum_acc;
                        d.lo_half = 1'b0;
                    end else if (in_byte == ID_HI) begin
                        d.st      = P_ID1;
                        d.sum     = {in_byte, 8'h00};
                        d.lo_half = 1'b1;
                    end else begin
                        d.st = P_ID0;
                    end
                end
                P_FLAGS: begin
                    d.hdr.flags = in_byte;
                    d.sum       = sum_acc;
                    d.lo_half   = ~q.lo_half;
                    d.st        = P_LEN;
                end
                P_LEN: begin
                    d.hdr.len = in_byte;
                    d.sum     = sum_acc;
                    d.lo_half = ~q.lo_half;
                    d.st      = P_CID0;
                end
                P_CID0: begin
                    d.hdr.cid0 = in_byte;
                    d.sum      = sum_acc;
                    d.lo_half  = ~q.lo_half;
                    d.st       = P_CID1;
                end
                P_CID1: begin
                    d.hdr.cid1 = in_byte;
                    d.sum      = sum_acc;
                    d.lo_half  = ~q.lo_half;
                    d.cnt      = '0;
                    if (q.hdr.len != '0) d.st = P_DATA;
                    else                 body_end = 1'b1;
                end
                P_DATA: begin
                    wr_en     = 1'b1;
                    d.sum     = sum_acc;
                    d.lo_half = ~q.lo_half;
                    d.cnt     = q.cnt + LEN_W'(1);
                    if (q.cnt == q.hdr.len - LEN_W'(1)) body_end = 1'b1;
                end
                P_CK0: begin
                    d.ck_hi = in_byte;
                    d.st    = P_CK1;
                end
                P_CK1: begin
                    done    = 1'b1;
                    done_ok = ({q.ck_hi, in_byte} == q.sum);
                    d.st    = P_ID0;
                end
                default: d.st = P_ID0;
            endcase

            if (body_end) begin
                if (d.hdr.flags[FLAG_CSUM]) begin
                    d.st = P_CK0;
                end else begin
                    d.st    = P_ID0;
                    done    = 1'b1;
                    done_ok = 1'b1;
                end
            end
        end
    end

    assign hunting  = (q.st == P_ID0);
    assign done_hdr = d.hdr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= P_ID0;
            q.hdr     <= '0;
            q.cnt     <= '0;
            q.sum     <= '0;
            q.lo_half <= 1'b0;
            q.ck_hi   <= '0;
        end else begin
            q <= d;
        end
    end

    AST_HUNT_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        gap_expire |=> (q.st == P_ID0)); // R10
    AST_DATA_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == P_DATA) |-> (q.cnt < q.hdr.len)); // R3
    AST_ID_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == P_ID0 && in_valid && in_byte != ID_HI) |=> (q.st == P_ID0)); // R1

endmodule

// File: rtl/cfp_mode_ctrl.sv
module cfp_mode_ctrl
    import cfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  done,
    input  logic  done_ok,
    input  hdr_t  done_hdr,
    output mode_e mode,
    output logic  cmd_valid,
    output hdr_t  cmd_hdr,
    output logic  ack_valid
);
    typedef struct packed {
        mode_e mode;
        logic  cmd_v;
        logic  ack_v;
        hdr_t  hdr;
    } mst_t;

    mst_t q, d;
    logic is_init;
    logic allowed;

    always_comb begin
        d       = q;
        d.cmd_v = 1'b0;
        d.ack_v = 1'b0;
        is_init = ((done_hdr.cid0 == CID0_SPI) || (done_hdr.cid0 == CID0_PWM))
                  && (done_hdr.cid1 == CID1_INIT);
        allowed = is_init ? (q.mode == M_CONF_PERIPH) : (q.mode == M_NORMAL);

        if (done) begin
            if (!done_ok) begin
                d.mode = M_STOP;
            end else begin
                d.ack_v = done_hdr.flags[FLAG_ACK];
                if (done_hdr.cid0 == CID0_MODE) begin
                    if (done_hdr.cid1 <= 8'd4) d.mode = mode_e'(done_hdr.cid1[2:0]);
                    else                       d.mode = M_STOP;
                end else if (allowed) begin
                    d.cmd_v = 1'b1;
                    d.hdr   = done_hdr;
                end else begin
                    d.mode = M_STOP;
                end
            end
        end
    end

    assign mode      = q.mode;
    assign cmd_valid = q.cmd_v;
    assign cmd_hdr   = q.hdr;
    assign ack_valid = q.ack_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode  <= M_CONF_COM;
            q.cmd_v <= 1'b0;
            q.ack_v <= 1'b0;
            q.hdr   <= '0;
        end else begin
            q <= d;
        end
    end

    AST_BAD_SUM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |=> (q.mode == M_STOP && !q.cmd_v && !q.ack_v)); // R4
    AST_TRANS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ok && done_hdr.cid0 == CID0_MODE && done_hdr.cid1 <= 8'd4)
        |=> (q.mode == $past(done_hdr.cid1[2:0]) && !q.cmd_v)); // R8
    AST_INIT_IN_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd_v && q.hdr.cid1 == CID1_INIT && (q.hdr.cid0 == CID0_SPI || q.hdr.cid0 == CID0_PWM))
        |-> ($past(q.mode) == M_CONF_PERIPH)); // R9
    AST_ACK_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        q.ack_v |-> $past(done && done_ok)); // R6

endmodule

// File: rtl/cfp_payload_buf.sv
module cfp_payload_buf #(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]               rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/cfp_frame_parser.sv
module cfp_frame_parser
    import cfp_pkg::*;
#(
    parameter int         GAP_LIMIT = 1024,
    parameter logic [7:0] ACK_CODE  = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             cmd_valid,
    output logic [7:0]       cmd_cid0,
    output logic [7:0]       cmd_cid1,
    output logic [7:0]       cmd_len,
    output logic [7:0]       cmd_flags,
    input  logic [LEN_W-1:0] pld_addr,
    output logic [7:0]       pld_data,
    output logic             ack_valid,
    output logic [7:0]       ack_byte,
    output logic [2:0]       mode
);
    logic             hunting;
    logic             gap_expire;
    logic             wr_en;
    logic [LEN_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic             done;
    logic             done_ok;
    hdr_t             done_hdr;
    hdr_t             cmd_hdr;
    mode_e            mode_st;

    cfp_gap_timer #(.LIMIT(GAP_LIMIT)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (!hunting),
        .byte_seen (in_valid),
        .expire    (gap_expire)
    );

    cfp_byte_parser u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .gap_expire (gap_expire),
        .hunting    (hunting),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .done       (done),
        .done_ok    (done_ok),
        .done_hdr   (done_hdr)
    );

    cfp_payload_buf #(.DEPTH(PLD_DEPTH)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (pld_addr),
        .rd_data (pld_data)
    );

    cfp_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .done_ok   (done_ok),
        .done_hdr  (done_hdr),
        .mode      (mode_st),
        .cmd_valid (cmd_valid),
        .cmd_hdr   (cmd_hdr),
        .ack_valid (ack_valid)
    );

    assign cmd_cid0  = cmd_hdr.cid0;
    assign cmd_cid1  = cmd_hdr.cid1;
    assign cmd_len   = cmd_hdr.len;
    assign cmd_flags = cmd_hdr.flags;
    assign ack_byte  = ack_valid ? ACK_CODE : 8'h00;
    assign mode      = mode_st;

endmodule

// File: tb/cfp_frame_parser_bench.sv
module cfp_frame_parser_bench;

    typedef struct packed {
        logic [7:0] flags;
        logic [7:0] len;
        logic [7:0] cid0;
        logic [7:0] cid1;
        logic [7:0] seed;
        logic       exp_cmd;
        logic       exp_ack;
        logic [2:0] exp_mode;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'hA0, 8'd0,  8'h10, 8'h01, 8'h00, 1'b0, 1'b1, 3'd1},
        '{8'h20, 8'd3,  8'h01, 8'h00, 8'h11, 1'b1, 1'b0, 3'd1},
        '{8'hA0, 8'd2,  8'h02, 8'h00, 8'h40, 1'b1, 1'b1, 3'd1},
        '{8'h20, 8'd4,  8'h01, 8'h01, 8'h22, 1'b0, 1'b0, 3'd4},
        '{8'h00, 8'd0,  8'h10, 8'h03, 8'h00, 1'b0, 1'b0, 3'd3},
        '{8'h29, 8'd5,  8'h01, 8'h01, 8'h07, 1'b1, 1'b0, 3'd3},
        '{8'h80, 8'd2,  8'h02, 8'h0D, 8'hC0, 1'b1, 1'b1, 3'd3},
        '{8'h20, 8'd1,  8'h02, 8'h00, 8'h5A, 1'b0, 1'b0, 3'd4},
        '{8'h20, 8'd0,  8'h10, 8'h02, 8'h00, 1'b0, 1'b0, 3'd2},
        '{8'h20, 8'd3,  8'h01, 8'h01, 8'h33, 1'b0, 1'b0, 3'd4},
        '{8'hA0, 8'd0,  8'h10, 8'h07, 8'h00, 1'b0, 1'b1, 3'd4},
        '{8'h20, 8'd0,  8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0},
        '{8'h20, 8'd12, 8'h01, 8'h0C, 8'h03, 1'b0, 1'b0, 3'd4},
        '{8'h20, 8'd0,  8'h10, 8'h03, 8'h00, 1'b0, 1'b0, 3'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] pld_addr = 8'h00;
    logic       cmd_valid, ack_valid;
    logic [7:0] cmd_cid0, cmd_cid1, cmd_len, cmd_flags, pld_data, ack_byte;
    logic [2:0] mode;

    int errors = 0;
    int checks = 0;
    logic [7:0] fr [0:270];
    int fl;

    always #4 clk = ~clk;

    cfp_frame_parser u_cfp_frame_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .cmd_valid (cmd_valid),
        .cmd_cid0  (cmd_cid0),
        .cmd_cid1  (cmd_cid1),
        .cmd_len   (cmd_len),
        .cmd_flags (cmd_flags),
        .pld_addr  (pld_addr),
        .pld_data  (pld_data),
        .ack_valid (ack_valid),
        .ack_byte  (ack_byte),
        .mode      (mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [7:0] flags, input logic [7:0] len,
                         input logic [7:0] c0, input logic [7:0] c1,
                         input logic [7:0] seed, input bit corrupt);
        logic [15:0] cs;
        fr[0] = 8'h93; fr[1] = 8'h01; fr[2] = flags; fr[3] = len;
        fr[4] = c0;    fr[5] = c1;
        for (int k = 0; k < int'(len); k++) fr[6+k] = 8'(int'(seed) + 3*k);
        fl = 6 + int'(len);
        cs = 16'h0000;
        for (int i = 0; i < fl; i++) begin
            if (i % 2 == 0) cs = cs ^ {fr[i], 8'h00};
            else            cs = cs ^ {8'h00, fr[i]};
        end
        if (corrupt) cs = cs ^ 16'h0001;
        if (flags[5]) begin
            fr[fl] = cs[15:8]; fr[fl+1] = cs[7:0];
            fl = fl + 2;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic send_range(input int lo, input int hi);
        for (int i = lo; i < hi; i++) send_byte(fr[i]);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        chk("R7 reset mode", int'(mode), 0);
        chk("R7 reset cmd_valid", int'(cmd_valid), 0);
        chk("R7 reset ack_valid", int'(ack_valid), 0);
        rst_n = 1'b1;
        idle(2);

        for (int v = 0; v < NV; v++) begin
            build(VECS[v].flags, VECS[v].len, VECS[v].cid0, VECS[v].cid1, VECS[v].seed, 1'b0);
            send_range(0, fl);
            chk($sformatf("R9 vec%0d cmd_valid", v), int'(cmd_valid), int'(VECS[v].exp_cmd));
            chk($sformatf("R6 vec%0d ack_valid", v), int'(ack_valid), int'(VECS[v].exp_ack));
            if (VECS[v].exp_ack) chk($sformatf("R6 vec%0d ack_byte", v), int'(ack_byte), 8'hA5);
            chk($sformatf("R8 vec%0d mode", v), int'(mode), int'(VECS[v].exp_mode));
            if (VECS[v].exp_cmd) begin
                chk($sformatf("R2 vec%0d cid0", v), int'(cmd_cid0), int'(VECS[v].cid0));
                chk($sformatf("R2 vec%0d cid1", v), int'(cmd_cid1), int'(VECS[v].cid1));
                chk($sformatf("R2 vec%0d len", v), int'(cmd_len), int'(VECS[v].len));
                chk($sformatf("R11 vec%0d flags", v), int'(cmd_flags), int'(VECS[v].flags));
                for (int k = 0; k < int'(VECS[v].len); k++) begin
                    pld_addr = 8'(k);
                    #1;
                    chk($sformatf("R4 vec%0d payload %0d", v, k), int'(pld_data),
                        (int'(VECS[v].seed) + 3*k) % 256);
                end
            end
            @(negedge clk);
            chk($sformatf("R2 vec%0d strobe drops", v), int'(cmd_valid), 0);
            chk($sformatf("R6 vec%0d ack drops", v), int'(ack_valid), 0);
        end

        // bad checksum in normal mode
        build(8'hA0, 8'd2, 8'h01, 8'h01, 8'h10, 1'b1);
        send_range(0, fl);
        chk("R4 bad sum no cmd", int'(cmd_valid), 0);
        chk("R4 bad sum no ack", int'(ack_valid), 0);
        chk("R4 bad sum stop", int'(mode), 4);
        build(8'h20, 8'd0, 8'h10, 8'h03, 8'h00, 1'b0);
        send_range(0, fl);
        chk("R8 back to normal", int'(mode), 3);

        // identifier hunt with junk, wrong second byte and doubled first byte
        build(8'h20, 8'd2, 8'h02, 8'h0D, 8'h61, 1'b0);
        send_byte(8'h55); send_byte(8'h01); send_byte(8'h93); send_byte(8'h02);
        send_byte(8'h93);
        send_range(0, fl);
        chk("R1 resync cmd_valid", int'(cmd_valid), 1);
        chk("R1 resync cid1", int'(cmd_cid1), 8'h0D);
        chk("R1 resync mode", int'(mode), 3);

        // maximum length payload
        build(8'h20, 8'd255, 8'h01, 8'h01, 8'h05, 1'b0);
        send_range(0, fl);
        chk("R3 len255 cmd_valid", int'(cmd_valid), 1);
        chk("R3 len255 len", int'(cmd_len), 255);
        pld_addr = 8'd0;   #1; chk("R3 len255 byte0", int'(pld_data), 8'h05);
        pld_addr = 8'd254; #1; chk("R3 len255 byte254", int'(pld_data), (5 + 3*254) % 256);

        // gap shorter than limit: frame resumes
        build(8'h20, 8'd1, 8'h02, 8'h0D, 8'h09, 1'b0);
        send_range(0, 5);
        idle(1000);
        chk("R10 short gap no early cmd", int'(cmd_valid), 0);
        send_range(5, fl);
        chk("R10 short gap cmd_valid", int'(cmd_valid), 1);
        chk("R10 short gap cid1", int'(cmd_cid1), 8'h0D);

        // gap past limit: partial frame dropped, fresh frame accepted
        send_range(0, 5);
        idle(1030);
        chk("R10 long gap no cmd", int'(cmd_valid), 0);
        chk("R10 long gap mode kept", int'(mode), 3);
        build(8'h20, 8'd1, 8'h02, 8'h0C, 8'h0B, 1'b0);
        send_range(0, fl);
        chk("R10 after abort cmd_valid", int'(cmd_valid), 1);
        chk("R10 after abort cid1", int'(cmd_cid1), 8'h0C);
        chk("R10 after abort mode", int'(mode), 3);

        // no-checksum frame with zero length ends at CID1
        build(8'h00, 8'd0, 8'h02, 8'h0D, 8'h00, 1'b0);
        send_range(0, fl);
        chk("R5 no sum len0 cmd_valid", int'(cmd_valid), 1);
        chk("R3 no sum len0 len", int'(cmd_len), 0);

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule